// File: doc/BRIEF.md
# Open-Drain DDC Line Control Register

This block is a 32-bit memory-mapped control word through which software bit-bangs a two-wire display data channel. Two enable bits and two value bits select, per line, whether the clock line and the data line are pulled low or released. The pads are open-drain: a line is pulled low only when its enable bit is set and its value bit is clear; otherwise it floats high through the bus pull-up. The true line level is therefore the wired-AND of this block and every attached device. That level is synchronised and written back into two readback bits of the same word.

Drivers often update the word one byte at a time. In the gated variant, an update to the pads is allowed only by a write that software marks as intended. This keeps the intermediate register values of a multi-byte sequence from reaching the bus as glitch edges. In the ungated variant, every write updates the pads. The parameter BASE shifts every control and readback bit as a group.

Top module: `ddc_gpio_reg`

## Requirements
- R1: After reset the register reads 0 and both pad pull-down outputs are 0 (both lines released).
- R2: A write changes only the byte lanes whose byte enable is set; the others keep their stored value, and reads return the stored word.
- R3: On a qualifying write, sda_pull_o becomes 1 exactly when bit BASE+16 (data enable) is 1 and bit BASE (data value) is 0. scl_pull_o becomes 1 exactly when bit BASE+17 (clock enable) is 1 and bit BASE+1 (clock value) is 0. With default BASE=1 these are bits 17, 1, 18 and 2. Pad outputs change one clock after the write and at no other time.
- R4: A line whose enable bit is 0 after a qualifying write is released (pull output 0) and reads back high.
- R5: In the gated variant, a write after which bit 25 (update mask) is 0 leaves both pad outputs unchanged.
- R6: In the gated variant, with bit 25 set after the merge, any write whose byte enables cover the lane holding the enable bits (lane 2 for BASE=1) is qualifying.
- R7: In the gated variant, a write that does not cover the enable lane qualifies only if it enables lane 0 and at least one enable bit is 1 after the merge. Writes to lanes 1 or 3 alone never change the pads, even when the stored bits call for a different drive.
- R8: A qualifying write clears bits 11:8. SYNC_STAGES+1 clocks later, bit BASE+9 holds the synchronised clock-line level and bit BASE+8 the data-line level (bits 10 and 9 for BASE=1). Until then both read 0.
- R9: Readback reflects the wired-AND line level: a line released locally but held low by an attached device reads back 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| be_i | input | 4 | Byte enables of the write |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Stored register word |
| scl_pull_o | output | 1 | Clock pad pull-down (1 = drive low) |
| sda_pull_o | output | 1 | Data pad pull-down (1 = drive low) |
| scl_i | input | 1 | Clock pad level |
| sda_i | input | 1 | Data pad level |

## Verification
The drive mapping is exercised with both enables set and both values low, with mixed values, and with the enables cleared. These patterns distinguish the enable bit from the value bit on each line and confirm that the two lines are not swapped. Single-byte write sequences are then applied in an order where the stored bits disagree with the pad state. An edge counter on the pads separates writes that must stay invisible (mask clear, lanes 1 and 3, lane 0 with enables clear) from those that must reach the bus (enable lane, lane 0 with an enable set). A behavioural open-drain responder that holds the data line low shows that readback reports the wired-AND level rather than the local drive. Readback is sampled both inside and after the settle window.

// File: rtl/ddc_gpio_pkg.sv
package ddc_gpio_pkg;
  localparam int REG_W  = 32;
  localparam int LANE_W = 8;
  localparam int LANES  = REG_W / LANE_W;
  localparam int RB_LO  = 8;   // readback field, cleared on every qualifying write
  localparam int RB_HI  = 11;

  typedef struct packed {
    logic scl;
    logic sda;
  } line_pair_t;
endpackage

// File: rtl/ddc_byte_merge.sv
module ddc_byte_merge #(
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic [LANES*LANE_W-1:0] old_i,
  input  logic [LANES*LANE_W-1:0] new_i,
  input  logic [LANES-1:0]        be_i,
  output logic [LANES*LANE_W-1:0] merged_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign merged_o[l*LANE_W +: LANE_W] = be_i[l] ? new_i[l*LANE_W +: LANE_W]
                                                  : old_i[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ddc_write_gate.sv
module ddc_write_gate #(
  parameter int LANES   = 4,
  parameter int EN_LANE = 2,
  parameter int GATED   = 1
) (
  input  logic             wr_en_i,
  input  logic [LANES-1:0] be_i,
  input  logic             mask_i,   // update mask after merge
  input  logic [1:0]       en_i,     // line enables after merge
  output logic             qual_o
);
  if (GATED != 0) begin : g_gated
    logic covers_en, lane0_live;
    assign covers_en  = be_i[EN_LANE];
    assign lane0_live = be_i[0] && (|en_i);
    assign qual_o     = wr_en_i && mask_i && (covers_en || lane0_live);
  end else begin : g_open
    logic unused;
    assign unused = mask_i ^ (|en_i) ^ (|be_i);
    assign qual_o = wr_en_i;
  end
endmodule

// File: rtl/ddc_sync.sv
module ddc_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] st_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_st
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) st_q[s] <= '1;   // idle bus is high
      else if (s == 0) st_q[s] <= d_i;
      else st_q[s] <= st_q[s-1];
    end
  end

  assign q_o = st_q[STAGES-1];
endmodule

// File: rtl/ddc_gpio_reg.sv
module ddc_gpio_reg
  import ddc_gpio_pkg::*;
#(
  parameter int BASE        = 1,
  parameter int GATED       = 1,
  parameter int MASK_BIT    = 25,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [LANES-1:0] be_i,
  input  logic [REG_W-1:0] wdata_i,
  output logic [REG_W-1:0] rdata_o,
  output logic             scl_pull_o,
  output logic             sda_pull_o,
  input  logic             scl_i,
  input  logic             sda_i
);
  localparam int SDA_VAL = BASE;
  localparam int SCL_VAL = BASE + 1;
  localparam int SDA_EN  = BASE + 16;
  localparam int SCL_EN  = BASE + 17;
  localparam int SDA_RB  = BASE + 8;
  localparam int SCL_RB  = BASE + 9;
  localparam int EN_LANE = SDA_EN / LANE_W;
  localparam int SETTLE  = SYNC_STAGES + 1;
  localparam int CNT_W   = $clog2(SETTLE + 1);

  logic [REG_W-1:0] reg_q, merged_w, next_w;
  logic             qual_w, capture_w;
  line_pair_t       pull_q, pad_w, sync_w;
  logic [CNT_W-1:0] cnt_q;

  ddc_byte_merge #(.LANES(LANES), .LANE_W(LANE_W)) u_merge (
    .old_i   (reg_q),
    .new_i   (wdata_i),
    .be_i    (wr_en_i ? be_i : '0),
    .merged_o(merged_w)
  );

  ddc_write_gate #(.LANES(LANES), .EN_LANE(EN_LANE), .GATED(GATED)) u_gate (
    .wr_en_i(wr_en_i),
    .be_i   (be_i),
    .mask_i (merged_w[MASK_BIT]),
    .en_i   ({merged_w[SCL_EN], merged_w[SDA_EN]}),
    .qual_o (qual_w)
  );

  assign pad_w = '{scl: scl_i, sda: sda_i};

  ddc_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pad_w),
    .q_o   (sync_w)
  );

  // A new qualifying write restarts the settle window; its own clear wins.
  assign capture_w = (cnt_q == CNT_W'(1)) && !qual_w;

  always_comb begin
    next_w = merged_w;
    if (qual_w) next_w[RB_HI:RB_LO] = '0;
    if (capture_w) begin
      next_w[SCL_RB] = sync_w.scl;
      next_w[SDA_RB] = sync_w.sda;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= '0;
      pull_q <= '0;
      cnt_q  <= '0;
    end else begin
      reg_q <= next_w;
      if (qual_w) begin
        pull_q.scl <= merged_w[SCL_EN] && !merged_w[SCL_VAL];
        pull_q.sda <= merged_w[SDA_EN] && !merged_w[SDA_VAL];
        cnt_q      <= CNT_W'(SETTLE);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - CNT_W'(1);
      end
    end
  end

  assign rdata_o    = reg_q;
  assign scl_pull_o = pull_q.scl;
  assign sda_pull_o = pull_q.sda;
endmodule

// File: rtl/ddc_gpio_chk.sv
module ddc_gpio_chk #(
  parameter int GATED = 1
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       be_lane0_i,
  input logic       be_en_lane_i,
  input logic       be_mask_lane_i,
  input logic       wmask_i,
  input logic       rmask_i,
  input logic       r_sda_en_i,
  input logic       r_sda_val_i,
  input logic       r_scl_en_i,
  input logic       r_scl_val_i,
  input logic [3:0] r_rb_i,
  input logic       scl_pull_o,
  input logic       sda_pull_o,
  input logic       qual_i
);
  // R3: pads move only on a write
  p_idle_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(scl_pull_o) && $stable(sda_pull_o));

  // R3: drive follows the stored enable/value bits after a qualifying write
  p_drive_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_i |=> (sda_pull_o == (r_sda_en_i && !r_sda_val_i))
            && (scl_pull_o == (r_scl_en_i && !r_scl_val_i)));

  // R8: readback nibble cleared by a qualifying write
  p_nib_clear_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    qual_i |=> r_rb_i == 4'h0);

  if (GATED != 0) begin : g_gated
    // R5: mask clear after merge keeps the pads still
    p_mask_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !(be_mask_lane_i ? wmask_i : rmask_i)
      |=> $stable(scl_pull_o) && $stable(sda_pull_o));

    // R7: writes missing both lane 0 and the enable lane never qualify
    p_side_lanes_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && !be_lane0_i && !be_en_lane_i |-> !qual_i);

    // R6: enable-lane write with mask set always qualifies
    p_en_lane_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_en_i && be_en_lane_i && (be_mask_lane_i ? wmask_i : rmask_i) |-> qual_i);
  end
endmodule

bind ddc_gpio_reg ddc_gpio_chk #(.GATED(GATED)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .wr_en_i       (wr_en_i),
  .be_lane0_i    (be_i[0]),
  .be_en_lane_i  (be_i[(BASE + 16) / 8]),
  .be_mask_lane_i(be_i[MASK_BIT / 8]),
  .wmask_i       (wdata_i[MASK_BIT]),
  .rmask_i       (rdata_o[MASK_BIT]),
  .r_sda_en_i    (rdata_o[BASE + 16]),
  .r_sda_val_i   (rdata_o[BASE]),
  .r_scl_en_i    (rdata_o[BASE + 17]),
  .r_scl_val_i   (rdata_o[BASE + 1]),
  .r_rb_i        (rdata_o[11:8]),
  .scl_pull_o    (scl_pull_o),
  .sda_pull_o    (sda_pull_o),
  .qual_i        (qual_w)
);

// File: tb/sim_ddc_gpio_reg.sv
module sim_ddc_gpio_reg;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        scl_pull, sda_pull;
  logic        scl_pad, sda_pad;
  logic        dev_scl_low = 1'b0, dev_sda_low = 1'b0;
  logic        watch = 1'b0;
  int          checks = 0, fails = 0, edges = 0;

  always #5 clk = ~clk;

  // open-drain bus with pull-up: wired-AND of local drive and responder
  assign scl_pad = !scl_pull && !dev_scl_low;
  assign sda_pad = !sda_pull && !dev_sda_low;

  ddc_gpio_reg u0 (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .be_i(be), .wdata_i(wdata),
    .rdata_o(rdata), .scl_pull_o(scl_pull), .sda_pull_o(sda_pull),
    .scl_i(scl_pad), .sda_i(sda_pad)
  );

  always @(scl_pull, sda_pull) if (watch) edges++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; be = b; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; be = '0; wdata = '0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 rdata", rdata, 32'h0);
    chk("R1 pulls", {30'b0, scl_pull, sda_pull}, 32'h0);
  endtask

  task automatic t_merge();
    wr(4'b0010, 32'hAAAA_5A11);
    chk("R2 lane1", rdata, 32'h0000_5A00);
    wr(4'b1000, 32'h3C00_0000);
    chk("R2 lane3", rdata, 32'h3C00_5A00);
    wr(4'hF, 32'h0);
    chk("R2 full", rdata, 32'h0);
  endtask

  task automatic t_drive();
    wr(4'hF, 32'h0206_0000);
    chk("R3 both low", {30'b0, scl_pull, sda_pull}, 32'h3);
    settle();
    chk("R3 readback low", rdata, 32'h0206_0000);
    wr(4'hF, 32'h0206_0004);
    chk("R3 scl released", {30'b0, scl_pull, sda_pull}, 32'h1);
    settle();
    chk("R3 readback mixed", rdata, 32'h0206_0404);
  endtask

  task automatic t_release();
    wr(4'hF, 32'h0200_0000);
    chk("R4 released", {30'b0, scl_pull, sda_pull}, 32'h0);
    settle();
    chk("R4 reads high", rdata, 32'h0200_0600);
  endtask

  task automatic t_mask_clear();
    edges = 0; watch = 1'b1;
    wr(4'hF, 32'h0006_0000);
    settle();
    watch = 1'b0;
    chk("R5 no edges", edges, 0);
    chk("R5 stored", rdata, 32'h0006_0000);
  endtask

  task automatic t_side_lanes();
    edges = 0; watch = 1'b1;
    wr(4'b1000, 32'h0200_0000);
    wr(4'b0010, 32'h0000_FF00);
    settle();
    watch = 1'b0;
    chk("R7 side lanes no edges", edges, 0);
    chk("R7 side lanes stored", rdata, 32'h0206_FF00);
    wr(4'b0001, 32'h0);
    chk("R7 lane0 with enables drives", {30'b0, scl_pull, sda_pull}, 32'h3);
    chk("R8 nibble cleared", rdata, 32'h0206_F000);
    settle();
    chk("R8 settled low", rdata, 32'h0206_F000);
  endtask

  task automatic t_lane0_gate();
    // lines held low; stored bits then disagree without reaching the bus
    wr(4'hF, 32'h0);
    edges = 0; watch = 1'b1;
    wr(4'b1000, 32'h0200_0000);
    wr(4'b0001, 32'h0000_0006);
    settle();
    watch = 1'b0;
    chk("R7 lane0 no enables no edges", edges, 0);
    chk("R7 lines still low", {30'b0, scl_pull, sda_pull}, 32'h3);
    wr(4'b0100, 32'h0);
    chk("R6 enable lane qualifies", {30'b0, scl_pull, sda_pull}, 32'h0);
  endtask

  task automatic t_readback();
    wr(4'hF, 32'h0200_0F00);
    chk("R8 cleared at write", rdata, 32'h0200_0000);
    @(negedge clk);
    chk("R8 inside window", rdata, 32'h0200_0000);
    repeat (3) @(negedge clk);
    chk("R8 after window", rdata, 32'h0200_0600);
  endtask

  task automatic t_wired_and();
    dev_sda_low = 1'b1;
    wr(4'hF, 32'h0200_0000);
    chk("R9 local release", {31'b0, sda_pull}, 32'h0);
    settle();
    chk("R9 device holds sda", rdata, 32'h0200_0400);
    dev_sda_low = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    t_reset();
    t_merge();
    t_drive();
    t_release();
    t_mask_clear();
    t_side_lanes();
    t_lane0_gate();
    t_readback();
    t_wired_and();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule